// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit converts a 32-bit virtual address into a physical address using a single-level page table in memory. A CPU-side request carries the virtual address. The unit splits it into a 20-bit virtual page number and a 12-bit byte offset, which covers 4 KB pages. It compares the page number against the table length input. If the page number falls within the table, the unit reads one 4-byte entry through a memory read port. If the entry is marked resident, the unit joins the entry's frame number with the unchanged offset to form the physical address.

Two kinds of failure end a translation. A page number at or beyond the table length gives a bounds fault, and the unit issues no memory read for it. Because of this length limit the table can only grow upward from its base. An entry whose resident bit is clear gives a page fault. Only one translation is in flight at a time. The response holds the physical address, a fault flag and a cause code until the CPU takes it.

Top module: `pt_translate`

## Requirements
- R1: During reset and directly after it, `req_ready` is 1, while `rsp_valid` and `mem_rd_valid` are 0.
- R2: A request whose page number (`req_vaddr[31:12]`) is greater than or equal to `cfg_len` responds with `rsp_fault`=1 and `rsp_cause`=2'b10. No memory read is issued for it.
- R3: An in-bounds request issues exactly one memory read. The read address is `cfg_base + (page number << 2)`, using the values present when the request is accepted.
- R4: When entry bit 31 is 1, the response has `rsp_fault`=0, `rsp_cause`=2'b00 and `rsp_paddr` = {entry[19:0], `req_vaddr[11:0]`}.
- R5: When entry bit 31 is 0, the response has `rsp_fault`=1, `rsp_cause`=2'b01 and `rsp_paddr`=0.
- R6: Entry bits 30:20 have no effect on the response.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the response has been taken with `rsp_ready`.
- R8: `mem_rd_valid` and `mem_rd_addr` stay steady until `mem_rd_ready` is seen. The response outputs stay steady until `rsp_ready` is seen.
- R9: With `cfg_len`=0, every page number gives a bounds fault. Page number `cfg_len`-1 is in bounds, and with `cfg_len`=2^20 the highest page number is in bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Physical byte address of table entry 0 |
| cfg_len | input | 21 | Number of entries in the table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request accepted on this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 00 none, 01 page not resident, 10 out of bounds |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, 12-bit offset, 20-bit frame, 4-byte entries and the bounds check enabled. With these values the full 21-bit length range is reachable. That covers a zero length, a length equal to the page number, and the full 2^20-entry table. Random table bases and random small lengths put many page numbers on each side of the limit. The memory model returns entries hashed from their address, with random noise in the ignored bits, and it varies both the read-accept delay and the data delay.

// File: rtl/pt_types_pkg.sv
package pt_types_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_PAGE  = 2'b01,
      CAUSE_BOUND = 2'b10
   } fault_cause_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_RESP
   } walk_state_e;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
   parameter int VPN_W       = 20,
   parameter int PA_W        = 32,
   parameter int LEN_W       = 21,
   parameter int PTE_BYTES   = 4,
   parameter bit BOUND_CHECK = 1'b1
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LEN_W-1:0] tbl_len,
   input  logic [PA_W-1:0]  tbl_base,
   output logic             out_of_range,
   output logic [PA_W-1:0]  fetch_addr
);
   localparam int SHIFT = $clog2(PTE_BYTES);

   if (LEN_W != VPN_W + 1) begin : g_bad_len
      $error("pt_walk_addr: LEN_W must be VPN_W+1");
   end
   if ((1 << SHIFT) != PTE_BYTES) begin : g_bad_pte
      $error("pt_walk_addr: PTE_BYTES must be a power of two");
   end

   assign fetch_addr = tbl_base + (PA_W'(vpn) << SHIFT);

   if (BOUND_CHECK) begin : g_bound
      assign out_of_range = ({1'b0, vpn} >= tbl_len);
   end else begin : g_nobound
      logic unused_len;
      assign unused_len   = ^tbl_len;
      assign out_of_range = 1'b0;
   end

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
   parameter int PTE_W     = 32,
   parameter int FRAME_W   = 20,
   parameter int VALID_BIT = 31
) (
   input  logic [PTE_W-1:0]   pte,
   output logic               present,
   output logic [FRAME_W-1:0] frame
);
   if (VALID_BIT >= PTE_W || VALID_BIT < FRAME_W) begin : g_bad_valid
      $error("pt_entry_decode: valid bit must lie above the frame field");
   end

   logic unused_pte;
   assign unused_pte = ^pte;

   assign present = pte[VALID_BIT];
   assign frame   = pte[FRAME_W-1:0];

endmodule

// File: rtl/pt_translate.sv
module pt_translate #(
   parameter int VA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int FRAME_W     = 20,
   parameter int PTE_W       = 32,
   parameter int VALID_BIT   = 31,
   parameter bit BOUND_CHECK = 1'b1,
   localparam int VPN_W      = VA_W - OFF_W,
   localparam int PA_W       = FRAME_W + OFF_W,
   localparam int LEN_W      = VPN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PA_W-1:0]   cfg_base,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   output logic [1:0]        rsp_cause,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data
);
   import pt_types_pkg::*;

   if (OFF_W < 1 || OFF_W >= VA_W) begin : g_bad_off
      $error("pt_translate: OFF_W out of range");
   end
   if (PTE_W % 8 != 0) begin : g_bad_pte_w
      $error("pt_translate: PTE_W must be whole bytes");
   end

   walk_state_e        state_q;
   logic [PA_W-1:0]    fetch_q;
   logic [OFF_W-1:0]   off_q;
   logic [PA_W-1:0]    paddr_q;
   logic               fault_q;
   fault_cause_e       cause_q;

   logic [VPN_W-1:0]   req_vpn;
   logic               oob;
   logic [PA_W-1:0]    fetch_addr;
   logic               present;
   logic [FRAME_W-1:0] frame;
   logic               accept;

   assign req_vpn = req_vaddr[VA_W-1:OFF_W];
   assign accept  = req_valid && req_ready;

   pt_walk_addr #(
      .VPN_W(VPN_W), .PA_W(PA_W), .LEN_W(LEN_W),
      .PTE_BYTES(PTE_W / 8), .BOUND_CHECK(BOUND_CHECK)
   ) u_addr (
      .vpn(req_vpn), .tbl_len(cfg_len), .tbl_base(cfg_base),
      .out_of_range(oob), .fetch_addr(fetch_addr)
   );

   pt_entry_decode #(
      .PTE_W(PTE_W), .FRAME_W(FRAME_W), .VALID_BIT(VALID_BIT)
   ) u_dec (
      .pte(mem_rsp_data), .present(present), .frame(frame)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fetch_q <= '0;
         off_q   <= '0;
         paddr_q <= '0;
         fault_q <= 1'b0;
         cause_q <= CAUSE_NONE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               off_q <= req_vaddr[OFF_W-1:0];
               if (oob) begin
                  paddr_q <= '0;
                  fault_q <= 1'b1;
                  cause_q <= CAUSE_BOUND;
                  state_q <= ST_RESP;
               end else begin
                  fetch_q <= fetch_addr;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: if (mem_rd_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               if (present) begin
                  paddr_q <= {frame, off_q};
                  fault_q <= 1'b0;
                  cause_q <= CAUSE_NONE;
               end else begin
                  paddr_q <= '0;
                  fault_q <= 1'b1;
                  cause_q <= CAUSE_PAGE;
               end
               state_q <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign mem_rd_valid = (state_q == ST_FETCH);
   assign mem_rd_addr  = fetch_q;
   assign rsp_valid    = (state_q == ST_RESP);
   assign rsp_paddr    = paddr_q;
   assign rsp_fault    = fault_q;
   assign rsp_cause    = cause_q;

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);  // R7

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));  // R8

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_cause)));  // R8

   AST_PAGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && mem_rsp_valid) |=>
         (rsp_valid && (rsp_fault != $past(mem_rsp_data[VALID_BIT]))));  // R5

   AST_FRAME_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && mem_rsp_valid && mem_rsp_data[VALID_BIT]) |=>
         (rsp_paddr[PA_W-1:OFF_W] == $past(mem_rsp_data[FRAME_W-1:0])));  // R4

   if (BOUND_CHECK) begin : g_bound_ast
      AST_BOUND_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && ({1'b0, req_vpn} >= cfg_len)) |=>
            (rsp_valid && rsp_fault && rsp_cause == 2'b10));  // R2
   end

endmodule

// File: tb/sim_pt_translate.sv
module sim_pt_translate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [20:0] cfg_len = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int checks = 0;
   int errors = 0;
   int rd_count = 0;
   logic [31:0] last_rd_addr = '0;
   int countdown = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pt_translate u0 (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [31:0] pte_of(input logic [31:0] a);
      logic [31:0] h;
      h = a * 32'h9E3779B1;
      return {(h[27:25] != 3'b000), h[10:0], h[31:12]};
   endfunction

   always @(negedge clk) begin
      logic rdy;
      mem_rsp_valid <= 1'b0;
      if (countdown > 0) begin
         countdown = countdown - 1;
         if (countdown == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= pte_of(last_rd_addr);
         end
      end
      rdy = ($urandom % 3) != 0;
      mem_rd_ready <= rdy;
      if (mem_rd_valid && rdy && countdown == 0) begin
         rd_count     = rd_count + 1;
         last_rd_addr = mem_rd_addr;
         countdown    = 1 + ($urandom % 3);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic xlate(input logic [31:0] va, input logic [31:0] base,
                        input logic [20:0] len, input string req);
      logic [19:0] vpn;
      logic [31:0] eaddr, pte, epa, pa0;
      logic [1:0]  ecause;
      logic        efault, bnd;
      int          rd0, k;
      vpn   = va[31:12];
      bnd   = ({1'b0, vpn} >= len);
      eaddr = base + {vpn, 2'b00};
      pte   = pte_of(eaddr);
      if (bnd) begin
         efault = 1'b1; ecause = 2'b10; epa = '0;
      end else if (!pte[31]) begin
         efault = 1'b1; ecause = 2'b01; epa = '0;
      end else begin
         efault = 1'b0; ecause = 2'b00; epa = {pte[19:0], va[11:0]};
      end
      @(negedge clk);
      cfg_base  = base;
      cfg_len   = len;
      req_vaddr = va;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      rd0 = rd_count;
      @(negedge clk);
      req_valid = 1'b0;
      req_vaddr = $urandom;
      chk(req_ready == 1'b0, "R7", "busy after accept", 64'(req_ready), 64'd0);
      while (!rsp_valid) @(negedge clk);
      pa0 = rsp_paddr;
      k = $urandom % 3;
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         chk(rsp_valid && rsp_paddr == pa0 && req_ready == 1'b0, "R8",
             "response held", 64'(rsp_paddr), 64'(pa0));
      end
      chk(rsp_cause == ecause, bnd ? "R2" : (pte[31] ? "R4" : "R5"),
          {req, " cause"}, 64'(rsp_cause), 64'(ecause));
      chk(rsp_fault == efault, req, "fault flag", 64'(rsp_fault), 64'(efault));
      chk(rsp_paddr == epa, (!bnd && pte[31] && pte[30:20] != 0) ? "R6" : "R4",
          {req, " paddr"}, 64'(rsp_paddr), 64'(epa));
      if (bnd)
         chk(rd_count == rd0, "R2", "no read on bounds fault", 64'(rd_count - rd0), 64'd0);
      else begin
         chk(rd_count == rd0 + 1, "R3", "one read", 64'(rd_count - rd0), 64'd1);
         chk(last_rd_addr == eaddr, "R3", "entry address", 64'(last_rd_addr), 64'(eaddr));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R7", "idle after take",
          64'({rsp_valid, req_ready}), 64'h1);
   endtask

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_rd_valid, "R1", "in reset",
          64'({req_ready, rsp_valid, mem_rd_valid}), 64'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_rd_valid, "R1", "after reset",
          64'({req_ready, rsp_valid, mem_rd_valid}), 64'h4);

      // R9 directed corners
      xlate(32'h0000_0ABC, 32'h0040_0000, 21'd0, "R9 len0 vpn0");
      xlate(32'hFFFF_F123, 32'h0040_0000, 21'd0, "R9 len0 top");
      xlate({20'd9, 12'h345}, 32'h0040_0000, 21'd10, "R9 vpn=len-1");
      xlate({20'd10, 12'h345}, 32'h0040_0000, 21'd10, "R9 vpn=len");
      xlate(32'hFFFF_FFFF, 32'h0000_0000, 21'h100000, "R9 full table");
      for (int v = 0; v < 64; v++) begin
         if (!pte_of(32'h0080_0000 + 32'(v * 4))[31]) begin
            xlate({20'(v), 12'hFED}, 32'h0080_0000, 21'd64, "R5 not resident");
            break;
         end
      end
      for (int n = 0; n < 400; n++) begin
         logic [20:0] len;
         logic [19:0] vpn;
         logic [31:0] base;
         len  = 21'($urandom % 200);
         vpn  = 20'($urandom % (32'(len) + 8));
         base = {$urandom, 2'b00} & 32'hFFF0_FFFC;
         xlate({vpn, 12'($urandom)}, base, len, "rand");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule